// File: doc/BRIEF.md
# Serial Configuration Bitstream Streamer

This block plays the data side of a chainable serial configuration memory. It holds a small bit image in an on-chip ROM and shifts it out one bit per configuration clock edge, most significant bit of each byte first. Downstream logic, normally an FPGA's serial configuration port, reads the bits as they arrive. After a power-on event the block holds the shared reset/output-enable line low for a fixed number of cycles and then lets it go. An external low level on that same line rewinds the stream to its first bit and releases the data line.

The block has several outputs that can float. The reset line and the configuration-request line are open-drain, so each is modelled as a drive-low flag. The serial data output has its own output-enable flag, because all devices in a chain share one data wire. When the last image bit has been consumed, the cascade enable output goes low so that the next device in the chain can take over. A configuration-request input produces a bounded low pulse on the open-drain request line.

Top module: `cfg_bit_streamer`

## Requirements
- R1: While `oe_rst_ext_n` is low, `dout_oe` is 0 in the same cycle. Every clock edge that sees the line low returns the stream to bit index 0.
- R2: After `por_n` rises, `oe_rst_drv_lo` stays 1 for exactly POR_CYCLES clock edges and then stays 0. While it is 1 the block behaves as if the external line were low: `dout_oe` is 0 and the stream is held at bit 0.
- R3: While `ce_n` is high, `dout_oe` is 0 and the bit index does not move. When `ce_n` returns low, the stream resumes at the bit where it stopped.
- R4: With the block enabled, out of reset and not exhausted, each clock edge moves `dout` to the next image bit. Bit index a is bit (7 - a mod 8) of image byte k = a/8, and byte k holds (37*k + 90) mod 256.
- R5: The clock edge that consumes bit index IMG_BITS-1 drives `ceo_n` to 0 and `dout_oe` to 0.
- R6: `dout_oe` is 1 only when `ce_n` is low, the effective reset is released and the image is not exhausted. `dout` reads 0 whenever `dout_oe` is 0.
- R7: Once `ceo_n` is 0 it stays 0 through further clocks and `ce_n` changes. Only an effective reset returns it to 1, and that reset also rewinds the stream to bit 0.
- R8: If `cfg_req` is 1 at a clock edge while no pulse is running, `cf_drv_lo` is 1 for exactly CF_CYCLES cycles after that edge. Requests that arrive while a pulse is running are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| por_n | input | 1 | Power-good, active low asynchronous power-on reset |
| oe_rst_ext_n | input | 1 | External drive level on the reset/output-enable line (0 = pulled low) |
| oe_rst_drv_lo | output | 1 | Block pulls the reset/output-enable line low |
| ce_n | input | 1 | Active-low chip enable |
| cfg_req | input | 1 | Command to issue a configuration-request pulse |
| dout | output | 1 | Serial data bit |
| dout_oe | output | 1 | Drive enable for `dout` (0 = high impedance) |
| ceo_n | output | 1 | Active-low cascade enable to the next device |
| cf_drv_lo | output | 1 | Block pulls the open-drain configuration-request line low |

## Verification
A short table of enable and external-reset patterns is run against a reference bit index. It shows whether standby and reset each freeze the stream, rewind it or pass it on. A complete uninterrupted read compares every image bit, which separates a correct MSB-first order and byte content from reversed or shifted orderings. It also confirms that the handoff happens on exactly the last bit. Directed cases cover standby in the middle of the stream, a rewind in the middle of the stream, a rewind after the image is exhausted and the power-on hold length. They also cover the request pulse length with a request repeated during the pulse.

// File: rtl/cfg_bit_streamer.sv
module cfg_bit_streamer #(
  parameter int IMG_BITS   = 96,
  parameter int POR_CYCLES = 20,
  parameter int CF_CYCLES  = 5
) (
  input  logic clk,
  input  logic por_n,
  input  logic oe_rst_ext_n,
  output logic oe_rst_drv_lo,
  input  logic ce_n,
  input  logic cfg_req,
  output logic dout,
  output logic dout_oe,
  output logic ceo_n,
  output logic cf_drv_lo
);
  localparam int NBYTES = (IMG_BITS + 7) / 8;
  localparam int AW     = (IMG_BITS > 16) ? $clog2(IMG_BITS) : 4;
  localparam int PW     = $clog2(POR_CYCLES + 1);
  localparam int CW     = $clog2(CF_CYCLES + 1);
  localparam logic [AW-1:0] LAST = AW'(IMG_BITS - 1);

  logic [7:0]    rom [NBYTES];
  logic [AW-1:0] addr;
  logic          done;
  logic [PW-1:0] por_cnt;
  logic [CW-1:0] cf_cnt;
  logic          rst_eff;

  for (genvar k = 0; k < NBYTES; k++) begin : g_rom
    assign rom[k] = 8'((k * 37 + 90) % 256);
  end

  assign oe_rst_drv_lo = (por_cnt != PW'(POR_CYCLES));
  assign rst_eff       = !oe_rst_ext_n || oe_rst_drv_lo;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) por_cnt <= '0;
    else if (oe_rst_drv_lo) por_cnt <= por_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      addr <= '0;
      done <= 1'b0;
    end else if (rst_eff) begin
      addr <= '0;
      done <= 1'b0;
    end else if (!ce_n && !done) begin
      if (addr == LAST) done <= 1'b1;
      else addr <= addr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) cf_cnt <= '0;
    else if (cf_cnt != '0) cf_cnt <= cf_cnt - 1'b1;
    else if (cfg_req) cf_cnt <= CW'(CF_CYCLES);
  end

  assign cf_drv_lo = (cf_cnt != '0);
  assign ceo_n     = !done;
  assign dout_oe   = !ce_n && !rst_eff && !done;
  assign dout      = dout_oe && rom[addr[AW-1:3]][~addr[2:0]];
endmodule

module cfg_bit_streamer_chk #(
  parameter int AW = 7
) (
  input logic          clk,
  input logic          por_n,
  input logic          oe_rst_ext_n,
  input logic          oe_rst_drv_lo,
  input logic          ce_n,
  input logic          cfg_req,
  input logic          dout_oe,
  input logic          ceo_n,
  input logic          cf_drv_lo,
  input logic [AW-1:0] addr
);
  assert_ext_rst_float_R1: assert property (@(posedge clk) disable iff (!por_n)
    !oe_rst_ext_n |-> !dout_oe);

  assert_por_once_R2: assert property (@(posedge clk) disable iff (!por_n)
    !oe_rst_drv_lo |=> !oe_rst_drv_lo);

  assert_standby_hold_R3: assert property (@(posedge clk) disable iff (!por_n)
    (ce_n && oe_rst_ext_n && !oe_rst_drv_lo) |=> $stable(addr));

  assert_handoff_float_R5: assert property (@(posedge clk) disable iff (!por_n)
    !ceo_n |-> !dout_oe);

  assert_standby_float_R6: assert property (@(posedge clk) disable iff (!por_n)
    ce_n |-> !dout_oe);

  assert_ceo_sticky_R7: assert property (@(posedge clk) disable iff (!por_n)
    (!ceo_n && oe_rst_ext_n && !oe_rst_drv_lo) |=> !ceo_n);

  assert_cf_cause_R8: assert property (@(posedge clk) disable iff (!por_n)
    $rose(cf_drv_lo) |-> $past(cfg_req));
endmodule

bind cfg_bit_streamer cfg_bit_streamer_chk #(.AW(AW)) chk_i (
  .clk(clk), .por_n(por_n), .oe_rst_ext_n(oe_rst_ext_n),
  .oe_rst_drv_lo(oe_rst_drv_lo), .ce_n(ce_n), .cfg_req(cfg_req),
  .dout_oe(dout_oe), .ceo_n(ceo_n), .cf_drv_lo(cf_drv_lo), .addr(addr)
);

// File: tb/cfg_bit_streamer_tb.sv
module cfg_bit_streamer_tb_top;
  localparam int IMG_BITS   = 96;
  localparam int POR_CYCLES = 20;
  localparam int CF_CYCLES  = 5;

  logic clk = 1'b0;
  logic por_n, oe_rst_ext_n, ce_n, cfg_req;
  logic oe_rst_drv_lo, dout, dout_oe, ceo_n, cf_drv_lo;
  int total = 0, fails = 0;
  int m_addr = 0;
  bit m_done = 0;

  always #10 clk = ~clk;

  cfg_bit_streamer #(.IMG_BITS(IMG_BITS), .POR_CYCLES(POR_CYCLES), .CF_CYCLES(CF_CYCLES)) dut_i (
    .clk(clk), .por_n(por_n), .oe_rst_ext_n(oe_rst_ext_n), .oe_rst_drv_lo(oe_rst_drv_lo),
    .ce_n(ce_n), .cfg_req(cfg_req), .dout(dout), .dout_oe(dout_oe),
    .ceo_n(ceo_n), .cf_drv_lo(cf_drv_lo)
  );

  // {oe_rst_ext_n, ce_n}
  localparam logic [1:0] VEC [16] = '{
    2'b10, 2'b10, 2'b10, 2'b11, 2'b11, 2'b10, 2'b00, 2'b10,
    2'b10, 2'b01, 2'b10, 2'b11, 2'b10, 2'b10, 2'b00, 2'b10
  };

  function automatic bit expbit(int a);
    logic [7:0] b;
    b = 8'(((a / 8) * 37 + 90) % 256);
    return b[7 - (a % 8)];
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    #(20 * 150000);
    total++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int n;
    por_n = 0; oe_rst_ext_n = 1; ce_n = 1; cfg_req = 0;
    repeat (3) @(negedge clk);
    chk(oe_rst_drv_lo == 1, "R2 reset drive", oe_rst_drv_lo, 1);
    chk(dout_oe == 0, "R6 reset oe", dout_oe, 0);
    chk(ceo_n == 1, "R5 reset ceo", ceo_n, 1);
    chk(cf_drv_lo == 0, "R8 reset cf", cf_drv_lo, 0);

    ce_n = 0;
    por_n = 1;
    n = 0;
    while (oe_rst_drv_lo && n < 1000) begin
      #1 chk(dout_oe == 0, "R2 hold oe", dout_oe, 0);
      @(negedge clk);
      n++;
    end
    chk(n == POR_CYCLES, "R2 por length", n, POR_CYCLES);
    #1 chk(dout_oe == 1 && dout == expbit(0), "R2 first bit", dout, expbit(0));

    m_addr = 0; m_done = 0;
    for (int rep = 0; rep < 3; rep++) begin
      for (int i = 0; i < 16; i++) begin
        bit e, c;
        e = VEC[i][1]; c = VEC[i][0];
        oe_rst_ext_n = e; ce_n = c;
        #1;
        chk(dout_oe == (!c && e && !m_done), "R6 table oe", dout_oe, !c && e && !m_done);
        chk(ceo_n == !m_done, "R7 table ceo", ceo_n, !m_done);
        if (dout_oe) chk(dout == expbit(m_addr), "R4 table bit", dout, expbit(m_addr));
        @(negedge clk);
        if (!e) begin m_addr = 0; m_done = 0; end
        else if (!c && !m_done) begin
          if (m_addr == IMG_BITS - 1) m_done = 1; else m_addr++;
        end
      end
    end

    oe_rst_ext_n = 0; ce_n = 0;
    #1 chk(dout_oe == 0, "R1 ext low float", dout_oe, 0);
    @(negedge clk); oe_rst_ext_n = 1;
    for (int i = 0; i < IMG_BITS; i++) begin
      #1 chk(dout_oe == 1 && dout == expbit(i), "R4 stream bit", dout, expbit(i));
      @(negedge clk);
    end
    #1;
    chk(ceo_n == 0, "R5 handoff ceo", ceo_n, 0);
    chk(dout_oe == 0, "R5 handoff oe", dout_oe, 0);
    chk(dout == 0, "R6 released dout", dout, 0);
    repeat (3) @(negedge clk);
    chk(ceo_n == 0, "R7 ceo sticky", ceo_n, 0);
    ce_n = 1; repeat (2) @(negedge clk); ce_n = 0; #1;
    chk(ceo_n == 0, "R7 ceo after standby", ceo_n, 0);
    chk(dout_oe == 0, "R6 exhausted oe", dout_oe, 0);
    oe_rst_ext_n = 0; @(negedge clk); oe_rst_ext_n = 1; #1;
    chk(ceo_n == 1, "R7 ceo rewind", ceo_n, 1);
    chk(dout_oe == 1 && dout == expbit(0), "R7 rewind bit0", dout, expbit(0));

    repeat (10) @(negedge clk);
    #1 chk(dout == expbit(10), "R4 bit10", dout, expbit(10));
    oe_rst_ext_n = 0;
    #1 chk(dout_oe == 0, "R1 mid float", dout_oe, 0);
    @(negedge clk); oe_rst_ext_n = 1;
    #1 chk(dout_oe == 1 && dout == expbit(0), "R1 mid rewind", dout, expbit(0));

    repeat (5) @(negedge clk);
    ce_n = 1;
    for (int i = 0; i < 4; i++) begin
      #1 chk(dout_oe == 0, "R3 standby oe", dout_oe, 0);
      @(negedge clk);
    end
    ce_n = 0;
    #1 chk(dout_oe == 1 && dout == expbit(5), "R3 resume bit5", dout, expbit(5));

    cfg_req = 1;
    @(negedge clk);
    n = 0;
    while (cf_drv_lo && n < 100) begin
      n++;
      if (n == 2) cfg_req = 0;
      @(negedge clk);
    end
    chk(n == CF_CYCLES, "R8 pulse length", n, CF_CYCLES);
    @(negedge clk);
    chk(cf_drv_lo == 0, "R8 released", cf_drv_lo, 0);

    summary();
    $finish;
  end
endmodule